// File: doc/BRIEF.md
# Camera Byte-Pair to RGB888 Video Stream Capture

This block sits right after a parallel camera sensor. The sensor presents an 8-bit byte bus that is qualified by a line-active strobe and a frame-sync strobe. It sends every pixel as two consecutive bytes that together hold a 16-bit RGB565 value. The block joins each byte pair into one pixel and widens each colour field to eight bits. It then presents the result as a 24-bit beat on an AXI4-Stream video master. Frame start is marked on the stream's user bit and line end on its last bit.

The sensor cannot be paused. The block therefore never pushes back. If a beat is ready while the output slot still holds a beat the consumer has not taken, the new beat is discarded and a sticky overflow flag is raised. A one-pixel lookahead register holds the newest pixel until the next one completes or the line ends. This lets the final pixel of a line carry the last marker. The component widths and the order of the components on the output bus are compile-time parameters.

Top module: `cam_stream_capture`

## Requirements
- R1: While a line is active, bytes alternate between first and second of a pair. The first byte carries R[4:0] in bits 7:3 and G[5:3] in bits 2:0. The second carries G[2:0] in bits 7:5 and B[4:0] in bits 4:0. Exactly one pixel results per completed pair.
- R2: Each field is widened by appending its own top bits: red and blue become {c5, c5[4:2]} and green becomes {g6, g6[5:4]}.
- R3: With the default packing, tdata[23:16] is red, [15:8] is green and [7:0] is blue. With the packing parameter set to the reversed order, blue is in [23:16] and red in [7:0].
- R4: A byte is taken only when href is high and vsync is low. Every line starts on a first byte. A trailing odd byte at the end of a line is discarded. Bytes presented while vsync is high produce no pixel.
- R5: tuser is high on the first beat after a vsync pulse and low on every other beat.
- R6: tlast is high on the final pixel of each href-high interval and on no other beat. A line of one pixel carries tlast, and also tuser when it is the first line of the frame.
- R7: Once tvalid is high with tready low, tvalid stays high and tdata, tuser and tlast stay unchanged until the beat is accepted.
- R8: A beat produced while the output slot holds an unaccepted beat is dropped. The overflow output then goes high and stays high until reset.
- R9: After reset, tvalid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_vsync | input | 1 | Frame sync from the sensor, active high |
| cam_href | input | 1 | Line-active strobe from the sensor |
| cam_data | input | 8 | Sensor byte bus |
| m_tdata | output | 24 | Widened pixel, component order set by parameter |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Consumer ready |
| m_tuser | output | 1 | Frame-start marker |
| m_tlast | output | 1 | Line-end marker |
| overflow | output | 1 | Sticky flag for a dropped beat |

## Verification
The widening is tried with all-ones, all-zeros, each pure primary and irregular mixed values. All-ones and all-zeros expose stuck or missing replicated low bits. A pure primary exposes a swapped field or a wrong byte split, and the mixed values expose bit-order slips inside a field. A second instance with the reversed packing order separates the two packing variants. Lines of six, three and one pixels, a line with a trailing odd byte and bytes sent during vsync separate correct phase realignment and marker placement from off-by-one pairing. A line sent with the consumer stalled shows that the held beat stays intact while the later beats are dropped.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

   // Order of colour components on the output bus, most significant first
   typedef enum logic {
      PACK_RGB = 1'b0,
      PACK_BGR = 1'b1
   } pack_e;

   // Side-band markers travelling with a beat
   typedef struct packed {
      logic frame_start;
      logic line_end;
   } beat_mark_t;

endpackage

// File: rtl/cam_field_widen.sv
module cam_field_widen #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  fld_in,
   output logic [OUT_W-1:0] fld_out
);
   localparam int EXT_W = OUT_W - IN_W;

   if (IN_W < 1 || EXT_W < 0 || EXT_W > IN_W) begin : g_bad_width
      $error("cam_field_widen: unsupported widths");
   end

   if (EXT_W == 0) begin : g_pass
      assign fld_out = fld_in;
   end else begin : g_rep
      // low bits filled from the field's own top bits
      assign fld_out = {fld_in, fld_in[IN_W-1 -: EXT_W]};
   end
endmodule

// File: rtl/cam_rgb_widen.sv
module cam_rgb_widen
   import cam_cap_pkg::*;
#(
   parameter int    R_W    = 5,
   parameter int    G_W    = 6,
   parameter int    B_W    = 5,
   parameter int    COMP_W = 8,
   parameter pack_e PACK   = PACK_RGB,
   localparam int   PIX_W  = R_W + G_W + B_W,
   localparam int   OUT_W  = 3 * COMP_W
) (
   input  logic [PIX_W-1:0] pix,
   output logic [OUT_W-1:0] rgb
);
   localparam int B_LO = 0;
   localparam int G_LO = B_W;
   localparam int R_LO = B_W + G_W;

   logic [COMP_W-1:0] r8, g8, b8;

   cam_field_widen #(.IN_W(R_W), .OUT_W(COMP_W)) u_wr (
      .fld_in (pix[R_LO +: R_W]),
      .fld_out(r8)
   );
   cam_field_widen #(.IN_W(G_W), .OUT_W(COMP_W)) u_wg (
      .fld_in (pix[G_LO +: G_W]),
      .fld_out(g8)
   );
   cam_field_widen #(.IN_W(B_W), .OUT_W(COMP_W)) u_wb (
      .fld_in (pix[B_LO +: B_W]),
      .fld_out(b8)
   );

   if (PACK == PACK_RGB) begin : g_rgb
      assign rgb = {r8, g8, b8};
   end else begin : g_bgr
      assign rgb = {b8, g8, r8};
   end
endmodule

// File: rtl/cam_byte_pair.sv
module cam_byte_pair #(
   parameter int  BYTE_W = 8,
   localparam int PIX_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_act,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              pix_stb,
   output logic [PIX_W-1:0]  pix
);
   logic              second_q;
   logic [BYTE_W-1:0] first_q;

   // phase falls back to "first byte" whenever the line is not active
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         first_q  <= '0;
      end else if (!line_act) begin
         second_q <= 1'b0;
      end else begin
         second_q <= ~second_q;
         if (!second_q) first_q <= byte_in;
      end
   end

   assign pix_stb = line_act & second_q;
   assign pix     = {first_q, byte_in};

   AST_ONE_PIXEL_PER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      pix_stb |=> !pix_stb); // R1
endmodule

// File: rtl/cam_line_tracker.sv
module cam_line_tracker
   import cam_cap_pkg::*;
#(
   parameter int PIX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vsync,
   input  logic             line_act,
   input  logic             pix_stb,
   input  logic [PIX_W-1:0] pix,
   output logic             emit,
   output logic [PIX_W-1:0] emit_pix,
   output beat_mark_t       emit_mark
);
   logic             hold_v;
   logic [PIX_W-1:0] hold_pix;
   logic             hold_sof;
   logic             sof_armed;
   logic             emit_mid, emit_end;

   assign emit_mid = pix_stb & hold_v;
   assign emit_end = ~line_act & hold_v;
   assign emit     = emit_mid | emit_end;
   assign emit_pix = hold_pix;
   assign emit_mark.frame_start = hold_sof;
   assign emit_mark.line_end    = emit_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v    <= 1'b0;
         hold_pix  <= '0;
         hold_sof  <= 1'b0;
         sof_armed <= 1'b0;
      end else begin
         if (vsync)        sof_armed <= 1'b1;
         else if (pix_stb) sof_armed <= 1'b0;

         if (pix_stb) begin
            hold_v   <= 1'b1;
            hold_pix <= pix;
            hold_sof <= sof_armed;
         end else if (emit_end) begin
            hold_v <= 1'b0;
         end
      end
   end

   AST_LOOKAHEAD_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_act && $past(!line_act)) |-> !hold_v); // R6
endmodule

// File: rtl/cam_stream_capture.sv
module cam_stream_capture
   import cam_cap_pkg::*;
#(
   parameter int    BYTE_W = 8,
   parameter int    R_W    = 5,
   parameter int    G_W    = 6,
   parameter int    B_W    = 5,
   parameter int    COMP_W = 8,
   parameter pack_e PACK   = PACK_RGB,
   localparam int   PIX_W  = 2 * BYTE_W,
   localparam int   OUT_W  = 3 * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cam_vsync,
   input  logic              cam_href,
   input  logic [BYTE_W-1:0] cam_data,
   output logic [OUT_W-1:0]  m_tdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tuser,
   output logic              m_tlast,
   output logic              overflow
);
   if (R_W + G_W + B_W != PIX_W) begin : g_bad_split
      $error("cam_stream_capture: colour fields must fill a byte pair");
   end
   if (COMP_W < R_W || COMP_W < G_W || COMP_W < B_W) begin : g_bad_comp
      $error("cam_stream_capture: component width narrower than a field");
   end

   logic             line_act;
   logic             pix_stb;
   logic [PIX_W-1:0] pix;
   logic             emit;
   logic [PIX_W-1:0] emit_pix;
   beat_mark_t       emit_mark;
   logic [OUT_W-1:0] emit_rgb;
   logic             slot_free;

   assign line_act = cam_href & ~cam_vsync;

   cam_byte_pair #(.BYTE_W(BYTE_W)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_act(line_act),
      .byte_in (cam_data),
      .pix_stb (pix_stb),
      .pix     (pix)
   );

   cam_line_tracker #(.PIX_W(PIX_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .vsync    (cam_vsync),
      .line_act (line_act),
      .pix_stb  (pix_stb),
      .pix      (pix),
      .emit     (emit),
      .emit_pix (emit_pix),
      .emit_mark(emit_mark)
   );

   cam_rgb_widen #(
      .R_W(R_W), .G_W(G_W), .B_W(B_W), .COMP_W(COMP_W), .PACK(PACK)
   ) u_widen (
      .pix(emit_pix),
      .rgb(emit_rgb)
   );

   assign slot_free = ~m_tvalid | m_tready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_tvalid <= 1'b0;
         m_tdata  <= '0;
         m_tuser  <= 1'b0;
         m_tlast  <= 1'b0;
         overflow <= 1'b0;
      end else begin
         if (emit && slot_free) begin
            m_tvalid <= 1'b1;
            m_tdata  <= emit_rgb;
            m_tuser  <= emit_mark.frame_start;
            m_tlast  <= emit_mark.line_end;
         end else if (m_tready) begin
            m_tvalid <= 1'b0;
         end
         if (emit && !slot_free) overflow <= 1'b1;
      end
   end

   AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                   && $stable(m_tuser) && $stable(m_tlast))); // R7
   AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R8
   AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready && emit) |=> overflow); // R8
   AST_LAST_ONLY_OFF_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && slot_free && emit_mark.line_end) |-> !(cam_href && !cam_vsync)); // R6
endmodule

// File: tb/tb_cam_stream_capture.sv
module tb_cam_stream_capture;
   import cam_cap_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cam_vsync = 1'b0;
   logic        cam_href = 1'b0;
   logic [7:0]  cam_data = 8'h00;
   logic        m_tready = 1'b1;
   logic [23:0] m_tdata, b_tdata;
   logic        m_tvalid, m_tuser, m_tlast, overflow;
   logic        b_tvalid, b_tuser, b_tlast, b_overflow;

   always #2 clk = ~clk;

   cam_stream_capture dut (
      .clk(clk), .rst_n(rst_n), .cam_vsync(cam_vsync), .cam_href(cam_href),
      .cam_data(cam_data), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
      .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast),
      .overflow(overflow)
   );

   cam_stream_capture #(.PACK(PACK_BGR)) dut_bgr (
      .clk(clk), .rst_n(rst_n), .cam_vsync(cam_vsync), .cam_href(cam_href),
      .cam_data(cam_data), .m_tdata(b_tdata), .m_tvalid(b_tvalid),
      .m_tready(m_tready), .m_tuser(b_tuser), .m_tlast(b_tlast),
      .overflow(b_overflow)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // accepted beats
   logic [23:0] cap_d [0:31];
   logic [23:0] cap_b [0:31];
   logic        cap_u [0:31];
   logic        cap_l [0:31];
   int          nb = 0;
   logic [15:0] px [0:15];

   always @(negedge clk) begin
      if (rst_n && m_tvalid && m_tready && nb < 32) begin
         cap_d[nb] = m_tdata;
         cap_b[nb] = b_tdata;
         cap_u[nb] = m_tuser;
         cap_l[nb] = m_tlast;
         nb = nb + 1;
      end
   end

   function automatic logic [23:0] exp_rgb(input logic [15:0] p, input bit bgr);
      int r, g, b;
      r = p[15:11]; g = p[10:5]; b = p[4:0];
      r = (r << 3) | (r >> 2);
      g = (g << 2) | (g >> 4);
      b = (b << 3) | (b >> 2);
      if (bgr) return {b[7:0], g[7:0], r[7:0]};
      return {r[7:0], g[7:0], b[7:0]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 0; cam_vsync = 0; cam_href = 0; m_tready = 1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
   endtask

   task automatic vsync_pulse();
      @(posedge clk); #1 cam_vsync = 1;
      repeat (3) @(posedge clk);
      #1 cam_vsync = 0;
      repeat (2) @(posedge clk);
   endtask

   task automatic put_byte(input logic [7:0] b);
      @(posedge clk); #1 cam_href = 1; cam_data = b;
   endtask

   task automatic send_line(input int n, input bit odd);
      for (int i = 0; i < n; i++) begin
         put_byte(px[i][15:8]);
         put_byte(px[i][7:0]);
      end
      if (odd) put_byte(8'hFF);
      @(posedge clk); #1 cam_href = 0; cam_data = 8'h00;
      repeat (5) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check(m_tvalid == 0, "R9 tvalid after reset", m_tvalid, 0);
      check(overflow == 0, "R9 overflow after reset", overflow, 0);
   endtask

   task automatic t_colours();
      px[0] = 16'hFFFF; px[1] = 16'h0000; px[2] = 16'hF800;
      px[3] = 16'h07E0; px[4] = 16'h001F; px[5] = 16'h1234;
      vsync_pulse();
      nb = 0;
      send_line(6, 0);
      check(nb == 6, "R1 beat count", nb, 6);
      for (int i = 0; i < 6; i++) begin
         check(cap_d[i] == exp_rgb(px[i], 0), "R2 R3 widened data", cap_d[i], exp_rgb(px[i], 0));
         check(cap_b[i] == exp_rgb(px[i], 1), "R3 reversed packing", cap_b[i], exp_rgb(px[i], 1));
         check(cap_u[i] == (i == 0), "R5 tuser", cap_u[i], i == 0);
         check(cap_l[i] == (i == 5), "R6 tlast", cap_l[i], i == 5);
      end
   endtask

   task automatic t_second_line();
      px[0] = 16'hA5A5; px[1] = 16'h5A5A; px[2] = 16'h8410;
      nb = 0;
      send_line(3, 0);
      check(nb == 3, "R1 beat count line 2", nb, 3);
      for (int i = 0; i < 3; i++) begin
         check(cap_d[i] == exp_rgb(px[i], 0), "R2 data line 2", cap_d[i], exp_rgb(px[i], 0));
         check(cap_u[i] == 0, "R5 no tuser after first beat", cap_u[i], 0);
         check(cap_l[i] == (i == 2), "R6 tlast line 2", cap_l[i], i == 2);
      end
   endtask

   task automatic t_odd_byte();
      px[0] = 16'h3C71; px[1] = 16'hE00F;
      nb = 0;
      send_line(2, 1);
      check(nb == 2, "R4 odd byte discarded", nb, 2);
      px[0] = 16'h0821;
      nb = 0;
      send_line(1, 0);
      check(nb == 1, "R4 count after odd line", nb, 1);
      check(cap_d[0] == exp_rgb(16'h0821, 0), "R4 phase realigned", cap_d[0], exp_rgb(16'h0821, 0));
      check(cap_l[0] == 1 && cap_u[0] == 0, "R6 single-pixel line marks", {cap_u[0], cap_l[0]}, 2'b01);
   endtask

   task automatic t_vsync_bytes();
      nb = 0;
      @(posedge clk); #1 cam_vsync = 1;
      for (int i = 0; i < 4; i++) put_byte(8'h5A);
      @(posedge clk); #1 cam_href = 0; cam_vsync = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(nb == 0, "R4 no beat while vsync high", nb, 0);
      px[0] = 16'hC0DE;
      send_line(1, 0);
      check(nb == 1, "R4 count after vsync", nb, 1);
      check(cap_d[0] == exp_rgb(16'hC0DE, 0), "R2 data after vsync", cap_d[0], exp_rgb(16'hC0DE, 0));
      check(cap_u[0] == 1 && cap_l[0] == 1, "R5 R6 one-pixel first line", {cap_u[0], cap_l[0]}, 2'b11);
   endtask

   task automatic t_backpressure();
      px[0] = 16'h1357; px[1] = 16'h2468; px[2] = 16'hFFFF; px[3] = 16'h0001;
      vsync_pulse();
      @(posedge clk); #1 m_tready = 0;
      nb = 0;
      send_line(4, 0);
      for (int i = 0; i < 3; i++) begin
         check(m_tvalid == 1, "R7 tvalid held", m_tvalid, 1);
         check(m_tdata == exp_rgb(16'h1357, 0), "R7 data held", m_tdata, exp_rgb(16'h1357, 0));
         @(negedge clk);
      end
      check(overflow == 1, "R8 overflow raised", overflow, 1);
      @(posedge clk); #1 m_tready = 1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(nb == 1, "R8 later beats dropped", nb, 1);
      check(cap_u[0] == 1, "R5 held beat keeps tuser", cap_u[0], 1);
      check(overflow == 1, "R8 overflow sticky", overflow, 1);
      do_reset();
      check(overflow == 0, "R9 overflow cleared by reset", overflow, 0);
   endtask

   initial begin
      t_reset();
      t_colours();
      t_second_line();
      t_odd_byte();
      t_vsync_bytes();
      t_backpressure();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule